// File: doc/BRIEF.md
# Host Mailbox with Linear Command and Reply Queues

This block sits between a host CPU and an embedded secure processor. It holds a small shared message RAM and two queue pointer pairs. The host reaches the RAM through an indirect window, a control register and a data register. The control register sets a word offset and two independent auto-advance flags, one for writes and one for reads. Words are little-endian: byte 0 of a message sits in bits 7:0 of the first word. The processor side has its own direct RAM port and a pointer write port.

One pointer pair carries host-to-processor commands and the other carries processor-to-host replies. The queues are linear and never wrap. Every message starts at byte offset 0. The tail holds the byte offset of the last word written, not one past it. After each exchange the consumer writes both pointers back to zero. To send, the host fills the RAM, writes the command tail and then writes the command head. The head write raises a doorbell pulse toward the processor. Each pair reports a message-present flag and a byte length.

The host request channel is valid/ready. `host_ready` is held high, so no request is ever stalled and the host needs no back-pressure handling. A read request returns `rsp_valid` with `rsp_data` in the cycle after it is accepted. The response channel has no ready, so the host must take it in that cycle.

Top module: `mbox_queue_top`

## Requirements
- R1: After reset, every pointer, the window offset and both advance flags are zero. `doorbell`, `cmd_avail`, `rpl_avail` and both sizes are zero.
- R2: A host write to register 0 (window control) loads the word offset from bits OFF_W-1:0, the write-advance flag from bit 30 and the read-advance flag from bit 31. A read of register 0 returns the same layout.
- R3: A host write to register 1 (window data) stores the 32-bit word at the current offset, with message byte 0 in bits 7:0. The offset then advances by one only if the write-advance flag is set; otherwise the next write overwrites the same word.
- R4: A host read of register 1 returns the word at the current offset. The offset then advances by one only if the read-advance flag is set.
- R5: An offset advance from DEPTH-1 wraps to word 0.
- R6: Registers 2/3 are the command head/tail and registers 4/5 are the reply head/tail, all byte offsets. The low two bits of any pointer write are dropped and read back as zero.
- R7: A queue is empty (avail 0, size 0) when head equals tail. Otherwise its size is tail-head+4 when tail is at or above head, and 4 when tail is below head (the subtraction saturates at zero).
- R8: A host write to the command head drives `doorbell` high for exactly the following cycle. Writes to any other register leave it low.
- R9: The processor writes a pointer with `proc_ptr_sel` 0=command head, 1=command tail, 2=reply head, 3=reply tail. If the host writes the same pointer in the same cycle, the processor value is kept.
- R10: The processor RAM port reads any word combinationally and writes it on a clock edge. If the host window writes the same word in the same cycle, the processor value is kept.
- R11: Host register 6 reads the reply size and register 7 reads the command size.
- R12: `host_ready` is always 1. `rsp_valid` is high in the cycle after an accepted read and low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request ready (always 1) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| doorbell | output | 1 | One-cycle pulse after a command-head write |
| cmd_head | output | PTR_W | Command queue head |
| cmd_tail | output | PTR_W | Command queue tail |
| cmd_avail | output | 1 | Command present |
| cmd_size | output | PTR_W+1 | Command length in bytes |
| rpl_avail | output | 1 | Reply present |
| rpl_size | output | PTR_W+1 | Reply length in bytes |
| proc_ptr_we | input | 1 | Processor pointer write |
| proc_ptr_sel | input | 2 | Pointer select |
| proc_ptr_wdata | input | PTR_W | Processor pointer value |
| proc_ram_we | input | 1 | Processor RAM write |
| proc_ram_addr | input | OFF_W | Processor RAM word address |
| proc_ram_wdata | input | 32 | Processor RAM write data |
| proc_ram_rdata | output | 32 | Processor RAM read data |

## Verification
Two collisions can fall in the same cycle: a host window write and a processor RAM write to one word, and a host and a processor write to one pointer. The bench provokes each by driving both ports before the same clock edge. It judges the outcome through a later host read, which must return the processor value. The same host read path also confirms that the stored pointer keeps the processor value and not the host value.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  typedef enum logic [2:0] {
    REG_WCTL = 3'd0,
    REG_WDAT = 3'd1,
    REG_CMDH = 3'd2,
    REG_CMDT = 3'd3,
    REG_RPLH = 3'd4,
    REG_RPLT = 3'd5,
    REG_RSZ  = 3'd6,
    REG_CSZ  = 3'd7
  } mbq_reg_e;

  typedef enum logic [1:0] {
    PSEL_CMDH = 2'd0,
    PSEL_CMDT = 2'd1,
    PSEL_RPLH = 2'd2,
    PSEL_RPLT = 2'd3
  } mbq_psel_e;

  localparam int INCW_BIT = 30;
  localparam int INCR_BIT = 31;
  localparam int NUM_Q    = 2;
endpackage

// File: rtl/mbq_ram.sv
module mbq_ram #(
  parameter int DEPTH = 256,
  parameter int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [OFF_W-1:0] a_addr,
  input  logic [31:0]      a_wdata,
  output logic [31:0]      a_rdata,
  input  logic             b_we,
  input  logic [OFF_W-1:0] b_addr,
  input  logic [31:0]      b_wdata,
  output logic [31:0]      b_rdata
);
  logic [31:0] mem [DEPTH];

  // Port b is written last, so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  assign a_rdata = mem[a_addr];
  assign b_rdata = mem[b_addr];
endmodule

// File: rtl/mbq_window.sv
module mbq_window #(
  parameter int DEPTH = 256,
  parameter int OFF_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [OFF_W-1:0] ctl_off,
  input  logic             ctl_incw,
  input  logic             ctl_incr,
  input  logic             wr_step,
  input  logic             rd_step,
  output logic [OFF_W-1:0] off,
  output logic             incw,
  output logic             incr
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(DEPTH - 1);

  logic             adv;
  logic [OFF_W-1:0] off_nxt;

  assign adv     = (wr_step && incw) || (rd_step && incr);
  assign off_nxt = (off == LAST) ? '0 : off + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off  <= '0;
      incw <= 1'b0;
      incr <= 1'b0;
    end else if (ctl_we) begin
      off  <= ctl_off;
      incw <= ctl_incw;
      incr <= ctl_incr;
    end else if (adv) begin
      off <= off_nxt;
    end
  end
endmodule

// File: rtl/mbq_ptr_pair.sv
module mbq_ptr_pair #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we_head,
  input  logic             h_we_tail,
  input  logic [PTR_W-1:0] h_wdata,
  input  logic             p_we_head,
  input  logic             p_we_tail,
  input  logic [PTR_W-1:0] p_wdata,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             avail,
  output logic [PTR_W:0]   size
);
  logic [PTR_W-1:0] h_al, p_al;

  assign h_al = {h_wdata[PTR_W-1:2], 2'b00};
  assign p_al = {p_wdata[PTR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (p_we_head)      head <= p_al;
      else if (h_we_head) head <= h_al;
      if (p_we_tail)      tail <= p_al;
      else if (h_we_tail) tail <= h_al;
    end
  end

  always_comb begin
    avail = (head != tail);
    if (!avail)
      size = '0;
    else if (tail >= head)
      size = {1'b0, tail} - {1'b0, head} + (PTR_W+1)'(4);
    else
      size = (PTR_W+1)'(4);
  end
endmodule

// File: rtl/mbox_queue_top.sv
module mbox_queue_top
  import mbq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFF_W = $clog2(DEPTH),
  parameter int PTR_W = OFF_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_write,
  input  logic [2:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             doorbell,
  output logic [PTR_W-1:0] cmd_head,
  output logic [PTR_W-1:0] cmd_tail,
  output logic             cmd_avail,
  output logic [PTR_W:0]   cmd_size,
  output logic             rpl_avail,
  output logic [PTR_W:0]   rpl_size,
  input  logic             proc_ptr_we,
  input  logic [1:0]       proc_ptr_sel,
  input  logic [PTR_W-1:0] proc_ptr_wdata,
  input  logic             proc_ram_we,
  input  logic [OFF_W-1:0] proc_ram_addr,
  input  logic [31:0]      proc_ram_wdata,
  output logic [31:0]      proc_ram_rdata
);
  mbq_reg_e   hreg;
  mbq_psel_e  psel;
  logic       acc, wr, rd;
  logic       win_ctl_we, win_wr, win_rd;
  logic [OFF_W-1:0] win_off;
  logic       win_incw, win_incr;
  logic [31:0] win_rdata;
  logic [31:0] rd_mux;

  logic [PTR_W-1:0] q_head [NUM_Q];
  logic [PTR_W-1:0] q_tail [NUM_Q];
  logic             q_avail[NUM_Q];
  logic [PTR_W:0]   q_size [NUM_Q];

  assign host_ready = 1'b1;
  assign hreg = mbq_reg_e'(host_addr);
  assign psel = mbq_psel_e'(proc_ptr_sel);
  assign acc  = host_valid && host_ready;
  assign wr   = acc && host_write;
  assign rd   = acc && !host_write;

  assign win_ctl_we = wr && (hreg == REG_WCTL);
  assign win_wr     = wr && (hreg == REG_WDAT);
  assign win_rd     = rd && (hreg == REG_WDAT);

  mbq_window #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (win_ctl_we),
    .ctl_off  (host_wdata[OFF_W-1:0]),
    .ctl_incw (host_wdata[INCW_BIT]),
    .ctl_incr (host_wdata[INCR_BIT]),
    .wr_step  (win_wr),
    .rd_step  (win_rd),
    .off      (win_off),
    .incw     (win_incw),
    .incr     (win_incr)
  );

  mbq_ram #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_ram (
    .clk     (clk),
    .a_we    (win_wr),
    .a_addr  (win_off),
    .a_wdata (host_wdata),
    .a_rdata (win_rdata),
    .b_we    (proc_ram_we),
    .b_addr  (proc_ram_addr),
    .b_wdata (proc_ram_wdata),
    .b_rdata (proc_ram_rdata)
  );

  // Queue 0 carries commands, queue 1 carries replies.
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam logic [2:0] HREG_H = 3'(REG_CMDH) + 3'(2 * q);
    localparam logic [1:0] PSEL_H = 2'(2 * q);
    logic hw_h, hw_t, pw_h, pw_t;
    assign hw_h = wr && (host_addr == HREG_H);
    assign hw_t = wr && (host_addr == HREG_H + 3'd1);
    assign pw_h = proc_ptr_we && (proc_ptr_sel == PSEL_H);
    assign pw_t = proc_ptr_we && (proc_ptr_sel == PSEL_H + 2'd1);

    mbq_ptr_pair #(.PTR_W(PTR_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_we_head (hw_h),
      .h_we_tail (hw_t),
      .h_wdata   (host_wdata[PTR_W-1:0]),
      .p_we_head (pw_h),
      .p_we_tail (pw_t),
      .p_wdata   (proc_ptr_wdata),
      .head      (q_head[q]),
      .tail      (q_tail[q]),
      .avail     (q_avail[q]),
      .size      (q_size[q])
    );
  end

  assign cmd_head  = q_head[0];
  assign cmd_tail  = q_tail[0];
  assign cmd_avail = q_avail[0];
  assign cmd_size  = q_size[0];
  assign rpl_avail = q_avail[1];
  assign rpl_size  = q_size[1];

  always_comb begin
    rd_mux = '0;
    unique case (hreg)
      REG_WCTL: begin
        rd_mux[OFF_W-1:0] = win_off;
        rd_mux[INCW_BIT]  = win_incw;
        rd_mux[INCR_BIT]  = win_incr;
      end
      REG_WDAT: rd_mux = win_rdata;
      REG_CMDH: rd_mux = 32'(q_head[0]);
      REG_CMDT: rd_mux = 32'(q_tail[0]);
      REG_RPLH: rd_mux = 32'(q_head[1]);
      REG_RPLT: rd_mux = 32'(q_tail[1]);
      REG_RSZ:  rd_mux = 32'(q_size[1]);
      REG_CSZ:  rd_mux = 32'(q_size[0]);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      doorbell  <= 1'b0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
      doorbell  <= wr && (hreg == REG_CMDH);
    end
  end

  logic unused_psel;
  assign unused_psel = ^psel;
endmodule

// File: rtl/mbq_chk.sv
module mbq_chk #(
  parameter int DEPTH = 256,
  parameter int OFF_W = $clog2(DEPTH),
  parameter int PTR_W = OFF_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_valid,
  input logic             host_write,
  input logic [2:0]       host_addr,
  input logic             doorbell,
  input logic             rsp_valid,
  input logic [OFF_W-1:0] win_off,
  input logic             win_incw,
  input logic [PTR_W-1:0] cmd_head,
  input logic [PTR_W-1:0] cmd_tail,
  input logic [PTR_W-1:0] rpl_head,
  input logic [PTR_W-1:0] rpl_tail,
  input logic             rpl_avail,
  input logic [PTR_W:0]   rpl_size
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(DEPTH - 1);

  // R8
  db_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_write && host_addr == 3'd2) |=> doorbell);
  // R8
  db_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(host_valid && host_write && host_addr == 3'd2));
  // R3
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_write && host_addr == 3'd1 && win_incw) |=>
      (win_off == (($past(win_off) == LAST) ? '0 : $past(win_off) + 1'b1)));
  // R7
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_head == rpl_tail) |-> (!rpl_avail && rpl_size == '0));
  // R7
  min_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_avail |-> (rpl_size >= (PTR_W+1)'(4)));
  // R6
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_head[1:0] == 2'b00) && (cmd_tail[1:0] == 2'b00) && (rpl_tail[1:0] == 2'b00));
  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> rsp_valid);
  // R12
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(host_valid && !host_write));
endmodule

bind mbox_queue_top mbq_chk #(.DEPTH(DEPTH), .OFF_W(OFF_W), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_valid (host_valid),
  .host_write (host_write),
  .host_addr  (host_addr),
  .doorbell   (doorbell),
  .rsp_valid  (rsp_valid),
  .win_off    (win_off),
  .win_incw   (win_incw),
  .cmd_head   (cmd_head),
  .cmd_tail   (cmd_tail),
  .rpl_head   (q_head[1]),
  .rpl_tail   (q_tail[1]),
  .rpl_avail  (rpl_avail),
  .rpl_size   (rpl_size)
);

// File: tb/sim_mbox_queue_top.sv
`timescale 1ns/1ps
module sim_mbox_queue_top;
  localparam int DEPTH = 256;
  localparam int OFF_W = 8;
  localparam int PTR_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_ready, rsp_valid, doorbell, cmd_avail, rpl_avail;
  logic [31:0] rsp_data, proc_ram_rdata;
  logic [PTR_W-1:0] cmd_head, cmd_tail;
  logic [PTR_W:0] cmd_size, rpl_size;
  logic proc_ptr_we = 1'b0;
  logic [1:0] proc_ptr_sel = '0;
  logic [PTR_W-1:0] proc_ptr_wdata = '0;
  logic proc_ram_we = 1'b0;
  logic [OFF_W-1:0] proc_ram_addr = '0;
  logic [31:0] proc_ram_wdata = '0;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  mbox_queue_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .doorbell(doorbell),
    .cmd_head(cmd_head), .cmd_tail(cmd_tail), .cmd_avail(cmd_avail), .cmd_size(cmd_size),
    .rpl_avail(rpl_avail), .rpl_size(rpl_size), .proc_ptr_we(proc_ptr_we),
    .proc_ptr_sel(proc_ptr_sel), .proc_ptr_wdata(proc_ptr_wdata),
    .proc_ram_we(proc_ram_we), .proc_ram_addr(proc_ram_addr),
    .proc_ram_wdata(proc_ram_wdata), .proc_ram_rdata(proc_ram_rdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    host_valid = 1'b0;
  endtask

  task automatic pptr(input logic [1:0] sel, input logic [PTR_W-1:0] d);
    @(negedge clk);
    proc_ptr_we = 1'b1; proc_ptr_sel = sel; proc_ptr_wdata = d;
    @(posedge clk); #1;
    proc_ptr_we = 1'b0;
  endtask

  // Monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data, e, t);
      end
    end
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({31'b0, doorbell}, 0, "R1 doorbell");
    check({31'b0, cmd_avail}, 0, "R1 cmd_avail");
    check(32'(rpl_size), 0, "R1 rpl_size");
    check({31'b0, host_ready}, 1, "R12 ready");
    hread(3'd0, 32'h0, "R1 window ctl");
    hread(3'd3, 32'h0, "R1 cmd tail");

    // R2 R3 R4: burst write then burst read from offset 0
    hwrite(3'd0, 32'h4000_0000);
    @(negedge clk);
    check({31'b0, rsp_valid}, 0, "R12 no rsp after write");
    hwrite(3'd1, 32'h1122_3344);
    hwrite(3'd1, 32'hAABB_CCDD);
    hwrite(3'd1, 32'h5566_7788);
    hread(3'd0, 32'h4000_0003, "R2 R3 ctl after writes");
    hwrite(3'd0, 32'h8000_0000);
    hread(3'd1, 32'h1122_3344, "R4 word0");
    hread(3'd1, 32'hAABB_CCDD, "R4 word1");
    hread(3'd1, 32'h5566_7788, "R4 word2");
    hread(3'd0, 32'h8000_0003, "R4 ctl after reads");

    // R3 R4 without advance
    hwrite(3'd0, 32'h0000_0005);
    hwrite(3'd1, 32'hDEAD_0001);
    hwrite(3'd1, 32'hBEEF_0002);
    hread(3'd1, 32'hBEEF_0002, "R3 overwrite");
    hread(3'd1, 32'hBEEF_0002, "R4 no advance");
    hread(3'd0, 32'h0000_0005, "R2 ctl readback");

    // R5 wrap
    hwrite(3'd0, 32'h4000_00FF);
    hwrite(3'd1, 32'hCAFE_00FF);
    hwrite(3'd1, 32'hCAFE_0000);
    hread(3'd0, 32'h4000_0001, "R5 write wrap");
    hwrite(3'd0, 32'h8000_00FF);
    hread(3'd1, 32'hCAFE_00FF, "R5 read last");
    hread(3'd1, 32'hCAFE_0000, "R5 read wrapped");

    // R10 processor RAM port
    @(negedge clk);
    proc_ram_addr = 8'hFF;
    #1 check(proc_ram_rdata, 32'hCAFE_00FF, "R10 proc read");
    @(negedge clk);
    proc_ram_we = 1'b1; proc_ram_addr = 8'd7; proc_ram_wdata = 32'h7777_0007;
    @(posedge clk); #1 proc_ram_we = 1'b0;
    hwrite(3'd0, 32'h0000_0007);
    hread(3'd1, 32'h7777_0007, "R10 proc write");
    hwrite(3'd0, 32'h0000_0009);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = 3'd1; host_wdata = 32'h1111_1111;
    proc_ram_we = 1'b1; proc_ram_addr = 8'd9; proc_ram_wdata = 32'h2222_2222;
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0; proc_ram_we = 1'b0;
    hread(3'd1, 32'h2222_2222, "R10 collision");

    // R6 R7 R8 command send
    hwrite(3'd3, 32'h0000_000F);
    @(negedge clk);
    check({31'b0, doorbell}, 0, "R8 no bell on tail");
    check(32'(cmd_size), 16, "R7 cmd size");
    check({31'b0, cmd_avail}, 1, "R7 cmd avail");
    hwrite(3'd2, 32'h0000_0000);
    @(negedge clk);
    check({31'b0, doorbell}, 1, "R8 bell");
    @(negedge clk);
    check({31'b0, doorbell}, 0, "R8 bell one cycle");
    check(32'(cmd_tail), 32'h0C, "R6 tail aligned");
    hread(3'd3, 32'h0000_000C, "R6 tail readback");
    hread(3'd7, 32'd16, "R11 cmd size reg");

    // R9 R7 reply pointers from processor
    pptr(2'd3, 10'd8);
    pptr(2'd2, 10'd0);
    @(negedge clk);
    check({31'b0, rpl_avail}, 1, "R9 reply avail");
    check(32'(rpl_size), 12, "R7 reply size");
    hread(3'd6, 32'd12, "R11 reply size reg");
    pptr(2'd2, 10'd12);
    @(negedge clk);
    check(32'(rpl_size), 4, "R7 saturate");
    pptr(2'd2, 10'd8);
    @(negedge clk);
    check({31'b0, rpl_avail}, 0, "R7 empty avail");
    check(32'(rpl_size), 0, "R7 empty size");

    // R9 collision on reply tail
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = 3'd5; host_wdata = 32'h20;
    proc_ptr_we = 1'b1; proc_ptr_sel = 2'd3; proc_ptr_wdata = 10'h40;
    @(posedge clk); #1;
    host_valid = 1'b0; host_write = 1'b0; proc_ptr_we = 1'b0;
    hread(3'd5, 32'h40, "R9 collision");

    // R6 host resets reply queue, low bits dropped
    hwrite(3'd5, 32'h0);
    hwrite(3'd4, 32'h0);
    @(negedge clk);
    check({31'b0, rpl_avail}, 0, "R6 reset reply");
    hwrite(3'd4, 32'h7);
    hread(3'd4, 32'h4, "R6 low bits");
    @(negedge clk);
    check(32'(rpl_size), 4, "R7 tail below head");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule